// File: doc/BRIEF.md
# Flash Self-Write Row Controller

This block lets a CPU reprogram its own 14-bit-word program flash, one 32-word row at a time, through a small byte-wide register file. Software sets a word address and a data word, then starts an action through a control register. The action runs only if a two-byte unlock pattern was written to a key register just before. An action can do one of three things. It can latch the data word into a row buffer. It can latch the final word and program the whole buffered row. It can erase a whole row. The flash array is reached through a plain port that carries a row number, the full 32-word row image and one-cycle erase and program strobes.

The CPU is stalled while an action runs. The two instruction slots after the start are forced to no-ops. A two-bit write-protect configuration can place the low quarter, the low half or the whole array out of reach. A blocked erase or program sets an error flag and leaves the array unchanged.

The unlock detector has three states. In U_IDLE a write of 55h to the key register moves it to U_HALF. In U_HALF a write of AAh to the key register moves it to U_ARMED. Any other accepted write returns it to U_IDLE, except that a key write of 55h always goes to U_HALF. The sequencer has five states:
- S_IDLE: on a start it moves to S_CHECK for an erase or to S_LOAD otherwise.
- S_LOAD: stores the word, then goes to S_FINISH for a latch-only action or to S_CHECK.
- S_CHECK: goes to S_FINISH when the target is protected. Otherwise it pulses the array strobe and enters S_RUN.
- S_RUN: counts OP_CYCLES cycles, then goes to S_FINISH.
- S_FINISH: returns to S_IDLE.

Top module: `fsw_row_ctrl`

## Requirements
- R1: After reset every register reads 0, and cpu_stall, force_nop, arr_erase and arr_prog are low.
- R2: An action starts only when three accepted writes come in this order: 55h to the key register (address 5), AAh to the key register, then a control write (address 4) with bit0 (start) and bit1 (enable) both 1. Control bit0 then reads 1 until the action ends.
- R3: A control write with the start bit does nothing when the unlock is incomplete or broken, or when enable is 0: there is no stall, no strobe, bit0 stays 0 and the array is unchanged. The unlock is broken by a write to any other register, by a wrong key value, or by keys in the wrong order. Any control write consumes the armed unlock.
- R4: With control bit3 (latch-only) = 1 and bit2 (erase) = 0, a start copies the 14-bit data register into buffer slot address[4:0] and pulses no strobe.
- R5: With bit3 = 0 and bit2 = 0, a start first latches the data word. It then pulses arr_prog once with arr_row = address[11:5] and all 32 buffer slots. A program only clears bits (cell = old AND new). Slots not loaded since the last program hold 3FFFh, and the buffer returns to all ones after a program strobe.
- R6: With bit2 = 1 (erase takes precedence over bit3), a start pulses arr_erase once for row address[11:5] and ignores address[4:0]. An erase leaves the buffer untouched, and a program never erases.
- R7: The row buffer slot comes from address[4:0] only. The row that is programmed is the one holding the final word's address, and no neighbouring row changes.
- R8: With write-protect 11 nothing is protected. With 10 word addresses below 1024 are protected, with 01 those below 2048, and with 00 every address. A protected erase or program pulses no strobe and sets control bit4 (error). Every accepted start clears bit4 first. Latch-only actions are never blocked.
- R9: cpu_stall is high from the cycle after the start until the action ends. force_nop is high for exactly the two cycles after the start write.
- R10: Control bit0 clears by itself when the action ends. cpu_stall lasts OP_CYCLES+3 cycles for a program, OP_CYCLES+2 for an erase, 2 for a latch-only action, 3 for a blocked program and 2 for a blocked erase.
- R11: Register writes that arrive while cpu_stall is high are ignored.
- R12: Reads are combinational:
  - address 0: address[7:0]
  - address 1: address[11:8]
  - address 2: data[7:0]
  - address 3: data[13:8]
  - address 4: {3'b0, error, latch-only, erase, enable, busy}
  - address 5 and higher: 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wp_cfg | input | 2 | Write-protect configuration |
| cpu_stall | output | 1 | Holds the CPU while an action runs |
| force_nop | output | 1 | Forces the two slots after a start to no-ops |
| arr_row | output | ADDR_W-ROW_BITS (7) | Row number for the array |
| arr_wdata | output | 32*WORD_W (448) | Full row image, slot i at bits [14i+13:14i] |
| arr_erase | output | 1 | One-cycle row erase strobe |
| arr_prog | output | 1 | One-cycle row program strobe |

## Verification
Directed unlock patterns are used to separate a correct detector from one that only looks at the last key or one that ignores intervening writes:
- a write to another register inside the pattern
- a write to another register after AAh
- the keys reversed
- a start with enable low followed by a second start

Latches placed at the top slot of a row followed by a final word at slot 0 show whether slots wrap inside the row or spill into the next one. Protection is probed just below and just above each boundary for each configuration. Seeded random rows, slot sets, data and protect settings mix partial-row programs with erases over a pre-filled array, so a missing AND, an unexpected erase or a stale buffer slot shows up as a row mismatch.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    // register map
    localparam logic [2:0] RA_ADDR_LO = 3'd0;
    localparam logic [2:0] RA_ADDR_HI = 3'd1;
    localparam logic [2:0] RA_DATA_LO = 3'd2;
    localparam logic [2:0] RA_DATA_HI = 3'd3;
    localparam logic [2:0] RA_CTRL    = 3'd4;
    localparam logic [2:0] RA_KEY     = 3'd5;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    // control register bit positions
    localparam int CB_GO    = 0;
    localparam int CB_EN    = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_LATCH = 3;

    typedef enum logic [1:0] {U_IDLE, U_HALF, U_ARMED} unlock_t;
    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CHECK, S_RUN, S_FINISH} seq_t;
    typedef enum logic [1:0] {
        WP_ALL     = 2'b00,
        WP_HALF    = 2'b01,
        WP_QUARTER = 2'b10,
        WP_NONE    = 2'b11
    } wp_t;
endpackage

// File: rtl/fsw_unlock.sv
module fsw_unlock
    import fsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_any,
    input  logic       wr_key,
    input  logic [7:0] key_data,
    output logic       armed
);
    unlock_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= U_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (wr_any) begin
            if (wr_key && key_data == KEY_FIRST) begin
                st_d = U_HALF;
            end else begin
                unique case (st_q)
                    U_HALF:  st_d = (wr_key && key_data == KEY_SECOND) ? U_ARMED : U_IDLE;
                    default: st_d = U_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        armed = (st_q == U_ARMED);
    end

    // R3
    armed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_key && key_data == KEY_SECOND));
endmodule

// File: rtl/fsw_wprot.sv
module fsw_wprot
    import fsw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wp_cfg,
    output logic              blocked
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int HALF    = DEPTH / 2;

    logic [ADDR_W:0] addr_x;
    assign addr_x = {1'b0, addr};

    always_comb begin
        unique case (wp_t'(wp_cfg))
            WP_NONE:    blocked = 1'b0;
            WP_QUARTER: blocked = addr_x < (ADDR_W+1)'(QUARTER);
            WP_HALF:    blocked = addr_x < (ADDR_W+1)'(HALF);
            default:    blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsw_row_buf.sv
module fsw_row_buf #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [$clog2(WORDS)-1:0]  ld_idx,
    input  logic [WORD_W-1:0]         ld_word,
    input  logic                      clr,
    output logic [WORDS*WORD_W-1:0]   row_flat
);
    localparam int IDX_W = $clog2(WORDS);

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '1;
            else if (clr)                              q <= '1;
            else if (ld_en && ld_idx == IDX_W'(g))     q <= ld_word;
        end
        assign row_flat[g*WORD_W +: WORD_W] = q;
    end
endmodule

// File: rtl/fsw_seq.sv
module fsw_seq
    import fsw_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 14,
    parameter int ROW_BITS  = 5,
    parameter int OP_CYCLES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       start_erase,
    input  logic                       start_latch,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic [WORD_W-1:0]          data_in,
    input  logic                       blocked,
    output logic [ADDR_W-1:0]          op_addr,
    output logic                       stall,
    output logic                       force_nop,
    output logic                       err,
    output logic                       arr_erase,
    output logic                       arr_prog,
    output logic [ADDR_W-ROW_BITS-1:0] arr_row,
    output logic                       ld_en,
    output logic [ROW_BITS-1:0]        ld_idx,
    output logic [WORD_W-1:0]          ld_word,
    output logic                       buf_clr
);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);

    seq_t              st_q, st_d;
    logic [ADDR_W-1:0] op_addr_q;
    logic [WORD_W-1:0] op_data_q;
    logic              op_erase_q, op_latch_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        nop_q;
    logic              err_q;
    logic              start_ok;

    assign start_ok = start && (st_q == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_ok) st_d = start_erase ? S_CHECK : S_LOAD;
            S_LOAD:   st_d = op_latch_q ? S_FINISH : S_CHECK;
            S_CHECK:  st_d = blocked ? S_FINISH : S_RUN;
            S_RUN:    if (cnt_q == '0) st_d = S_FINISH;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // operation context, timers and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_addr_q  <= '0;
            op_data_q  <= '0;
            op_erase_q <= 1'b0;
            op_latch_q <= 1'b0;
            cnt_q      <= '0;
            nop_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            if (start_ok) begin
                op_addr_q  <= addr_in;
                op_data_q  <= data_in;
                op_erase_q <= start_erase;
                op_latch_q <= start_latch;
                err_q      <= 1'b0;
                nop_q      <= 2'd2;
            end else if (nop_q != '0) begin
                nop_q <= nop_q - 2'd1;
            end
            if (st_q == S_CHECK) begin
                if (blocked) err_q <= 1'b1;
                else         cnt_q <= CNT_W'(OP_CYCLES - 1);
            end else if (st_q == S_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        stall     = (st_q != S_IDLE);
        force_nop = (nop_q != '0);
        err       = err_q;
        ld_en     = (st_q == S_LOAD);
        ld_idx    = op_addr_q[ROW_BITS-1:0];
        ld_word   = op_data_q;
        arr_row   = op_addr_q[ADDR_W-1:ROW_BITS];
        arr_erase = (st_q == S_CHECK) && !blocked && op_erase_q;
        arr_prog  = (st_q == S_CHECK) && !blocked && !op_erase_q;
        buf_clr   = arr_prog;
        op_addr   = op_addr_q;
    end

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_erase, arr_prog}));
    // R9
    strobe_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_erase || arr_prog) |=> stall);
    // R9
    nop_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_nop) |=> force_nop);
    // R10
    start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> stall);
endmodule

// File: rtl/fsw_row_ctrl.sv
module fsw_row_ctrl
    import fsw_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 14,
    parameter int ROW_BITS  = 5,
    parameter int OP_CYCLES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [2:0]                        reg_addr,
    input  logic [7:0]                        reg_wdata,
    output logic [7:0]                        reg_rdata,
    input  logic [1:0]                        wp_cfg,
    output logic                              cpu_stall,
    output logic                              force_nop,
    output logic [ADDR_W-ROW_BITS-1:0]        arr_row,
    output logic [(1<<ROW_BITS)*WORD_W-1:0]   arr_wdata,
    output logic                              arr_erase,
    output logic                              arr_prog
);
    localparam int ROW_WORDS = 1 << ROW_BITS;

    logic [ADDR_W-1:0]   addr_q, op_addr;
    logic [WORD_W-1:0]   data_q, ld_word;
    logic                en_q, erase_q, latch_q;
    logic                busy, accept, start, armed, blocked, err;
    logic                ld_en, buf_clr;
    logic [ROW_BITS-1:0] ld_idx;

    assign accept = reg_we && !busy;
    assign start  = accept && (reg_addr == RA_CTRL) && reg_wdata[CB_GO]
                    && reg_wdata[CB_EN] && armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            en_q    <= 1'b0;
            erase_q <= 1'b0;
            latch_q <= 1'b0;
        end else if (accept) begin
            unique case (reg_addr)
                RA_ADDR_LO: addr_q[7:0]        <= reg_wdata;
                RA_ADDR_HI: addr_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
                RA_DATA_LO: data_q[7:0]        <= reg_wdata;
                RA_DATA_HI: data_q[WORD_W-1:8] <= reg_wdata[WORD_W-9:0];
                RA_CTRL: begin
                    en_q    <= reg_wdata[CB_EN];
                    erase_q <= reg_wdata[CB_ERASE];
                    latch_q <= reg_wdata[CB_LATCH];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_ADDR_LO: reg_rdata = addr_q[7:0];
            RA_ADDR_HI: reg_rdata = 8'(addr_q[ADDR_W-1:8]);
            RA_DATA_LO: reg_rdata = data_q[7:0];
            RA_DATA_HI: reg_rdata = 8'(data_q[WORD_W-1:8]);
            RA_CTRL:    reg_rdata = {3'b000, err, latch_q, erase_q, en_q, busy};
            default:    reg_rdata = 8'h00;
        endcase
    end

    fsw_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_any   (accept),
        .wr_key   (accept && reg_addr == RA_KEY),
        .key_data (reg_wdata),
        .armed    (armed)
    );

    fsw_seq #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .ROW_BITS  (ROW_BITS),
        .OP_CYCLES (OP_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_erase (reg_wdata[CB_ERASE]),
        .start_latch (reg_wdata[CB_LATCH]),
        .addr_in     (addr_q),
        .data_in     (data_q),
        .blocked     (blocked),
        .op_addr     (op_addr),
        .stall       (busy),
        .force_nop   (force_nop),
        .err         (err),
        .arr_erase   (arr_erase),
        .arr_prog    (arr_prog),
        .arr_row     (arr_row),
        .ld_en       (ld_en),
        .ld_idx      (ld_idx),
        .ld_word     (ld_word),
        .buf_clr     (buf_clr)
    );

    fsw_wprot #(.ADDR_W(ADDR_W)) u_wprot (
        .addr    (op_addr),
        .wp_cfg  (wp_cfg),
        .blocked (blocked)
    );

    fsw_row_buf #(.WORDS(ROW_WORDS), .WORD_W(WORD_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_word  (ld_word),
        .clr      (buf_clr),
        .row_flat (arr_wdata)
    );

    assign cpu_stall = busy;

    // R11
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: tb/fsw_row_ctrl_tb.sv
`timescale 1ns/1ps
module fsw_row_ctrl_tb;
    import fsw_pkg::*;

    localparam int ADDR_W = 12, WORD_W = 14, ROW_BITS = 5, OP_CYCLES = 8;
    localparam int RW = 1 << ROW_BITS;
    localparam int NWORDS = 1 << ADDR_W;
    localparam int NROWS = NWORDS / RW;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [1:0] wp_cfg = 2'b11;
    logic cpu_stall, force_nop, arr_erase, arr_prog;
    logic [ADDR_W-ROW_BITS-1:0] arr_row;
    logic [RW*WORD_W-1:0] arr_wdata;

    always #4 clk = ~clk;

    fsw_row_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROW_BITS(ROW_BITS), .OP_CYCLES(OP_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wp_cfg(wp_cfg), .cpu_stall(cpu_stall), .force_nop(force_nop),
        .arr_row(arr_row), .arr_wdata(arr_wdata), .arr_erase(arr_erase), .arr_prog(arr_prog));

    logic [WORD_W-1:0] mem [NWORDS];
    logic [WORD_W-1:0] exp_mem [NWORDS];
    logic [WORD_W-1:0] exp_buf [RW];
    int n_chk = 0, n_fail = 0, n_prog_pulse = 0, n_erase_pulse = 0;
    bit exp_err = 1'b0;
    int cur_addr = 0, cur_data = 0;

    function automatic logic [WORD_W-1:0] init_pat(input int i);
        return WORD_W'(i * 40503 + 7) ^ WORD_W'(i >> 3);
    endfunction

    function automatic bit fn_blocked(input int a, input logic [1:0] wp);
        case (wp)
            2'b11:   return 1'b0;
            2'b10:   return a < NWORDS / 4;
            2'b01:   return a < NWORDS / 2;
            default: return 1'b1;
        endcase
    endfunction

    // flash array model: erase sets ones, program clears bits
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= init_pat(i);
        end else begin
            if (arr_erase) begin
                n_erase_pulse++;
                for (int i = 0; i < RW; i++) mem[int'(arr_row)*RW + i] <= '1;
            end
            if (arr_prog) begin
                n_prog_pulse++;
                for (int i = 0; i < RW; i++)
                    mem[int'(arr_row)*RW + i] <= mem[int'(arr_row)*RW + i] & arr_wdata[i*WORD_W +: WORD_W];
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_addr(input int a);
        wr(RA_ADDR_LO, 8'(a));
        wr(RA_ADDR_HI, 8'(a >> 8));
        cur_addr = a;
    endtask

    task automatic set_data(input int d);
        wr(RA_DATA_LO, 8'(d));
        wr(RA_DATA_HI, 8'(d >> 8));
        cur_data = d;
    endtask

    task automatic row_cmp(input string req, input string what, input int row);
        int bad = 0;
        for (int i = 0; i < RW; i++) if (mem[row*RW + i] !== exp_mem[row*RW + i]) bad++;
        chk(req, what, bad, 0);
    endtask

    task automatic launch(input logic [7:0] ctl, output int stall_n, output logic [2:0] nop_h);
        wr(RA_KEY, KEY_FIRST);
        wr(RA_KEY, KEY_SECOND);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RA_CTRL; reg_wdata = ctl;
        @(negedge clk);
        reg_we = 1'b0;
        stall_n = 0; nop_h = '0;
        for (int i = 0; i < 200 && (cpu_stall || i < 3); i++) begin
            if (i < 3) nop_h[i] = force_nop;
            if (cpu_stall) stall_n++;
            @(negedge clk);
        end
    endtask

    task automatic do_op(input bit er, input bit la, input string req);
        int sn, pb, eb, exp_stall, row;
        logic [2:0] nh;
        logic [7:0] ctl, rv;
        bit blk;
        pb = n_prog_pulse; eb = n_erase_pulse;
        row = cur_addr / RW;
        blk = fn_blocked(cur_addr, wp_cfg);
        ctl = 8'h03; ctl[2] = er; ctl[3] = la;
        launch(ctl, sn, nh);
        if (er) begin
            if (blk) begin exp_err = 1'b1; exp_stall = 2; end
            else begin
                for (int i = 0; i < RW; i++) exp_mem[row*RW + i] = '1;
                exp_err = 1'b0; exp_stall = OP_CYCLES + 2;
            end
        end else begin
            exp_buf[cur_addr % RW] = WORD_W'(cur_data);
            if (la) begin exp_err = 1'b0; exp_stall = 2; end
            else if (blk) begin exp_err = 1'b1; exp_stall = 3; end
            else begin
                for (int i = 0; i < RW; i++) exp_mem[row*RW + i] = exp_mem[row*RW + i] & exp_buf[i];
                for (int i = 0; i < RW; i++) exp_buf[i] = '1;
                exp_err = 1'b0; exp_stall = OP_CYCLES + 3;
            end
        end
        chk({req, " R10"}, "stall cycles", sn, exp_stall);
        chk("R9", "force_nop over 3 cycles", nh, 3'b011);
        chk(req, "program strobes", n_prog_pulse - pb, int'(!er && !la && !blk));
        chk(req, "erase strobes", n_erase_pulse - eb, int'(er && !blk));
        rd(RA_CTRL, rv);
        chk("R8", "error flag", rv[4], exp_err);
        chk("R10", "WR self-cleared", rv[0], 0);
        row_cmp(req, "row words mismatched", row);
    endtask

    task automatic no_start_check(input string what, input int pb, input int eb);
        logic [7:0] rv;
        chk("R3", {what, " stall"}, cpu_stall, 0);
        repeat (OP_CYCLES + 4) @(negedge clk);
        rd(RA_CTRL, rv);
        chk("R3", {what, " WR"}, rv[0], 0);
        chk("R3", {what, " strobes"}, (n_prog_pulse - pb) + (n_erase_pulse - eb), 0);
        row_cmp("R3", {what, " row"}, cur_addr / RW);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int pb, eb, seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < NWORDS; i++) exp_mem[i] = init_pat(i);
        for (int i = 0; i < RW; i++) exp_buf[i] = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(RA_CTRL, rv);    chk("R1", "ctrl after reset", rv, 0);
        rd(RA_ADDR_LO, rv); chk("R1", "addr lo after reset", rv, 0);
        rd(RA_DATA_HI, rv); chk("R1", "data hi after reset", rv, 0);
        chk("R1", "stall/nop/strobes", {cpu_stall, force_nop, arr_erase, arr_prog}, 0);

        // R12 read map
        set_addr(12'hABC);
        rd(RA_ADDR_LO, rv); chk("R12", "addr lo", rv, 8'hBC);
        rd(RA_ADDR_HI, rv); chk("R12", "addr hi", rv, 8'h0A);
        set_data(14'h2A5B);
        rd(RA_DATA_LO, rv); chk("R12", "data lo", rv, 8'h5B);
        rd(RA_DATA_HI, rv); chk("R12", "data hi", rv, 8'h2A);
        rd(RA_KEY, rv);     chk("R12", "key reads zero", rv, 0);

        // R6 erase ignores low address bits
        wp_cfg = 2'b11;
        set_addr(12'h0A7); do_op(1'b1, 1'b0, "R6");
        // R4 latch at top slot, R7 final word at slot 0 of the same row
        set_addr(12'h0BF); set_data(14'h1234); do_op(1'b0, 1'b1, "R4");
        set_addr(12'h0A0); set_data(14'h0F0F); do_op(1'b0, 1'b0, "R7");
        row_cmp("R7", "next row untouched", 6);
        // R5 program without erase only clears bits
        set_addr(12'h0A5); set_data(14'h3C3C); do_op(1'b0, 1'b0, "R5");

        // R2 / R11 busy read and ignored write
        set_addr(12'h123);
        wr(RA_KEY, KEY_FIRST); wr(RA_KEY, KEY_SECOND);
        wr(RA_CTRL, 8'h07);
        chk("R9", "stall right after start", cpu_stall, 1);
        wr(RA_ADDR_LO, 8'hEE);
        rd(RA_CTRL, rv); chk("R2", "WR reads 1 while busy", rv[0], 1);
        for (int i = 0; i < 100 && cpu_stall; i++) @(negedge clk);
        for (int i = 0; i < RW; i++) exp_mem[9*RW + i] = '1;
        exp_err = 1'b0;
        rd(RA_ADDR_LO, rv); chk("R11", "write during stall ignored", rv, 8'h23);
        row_cmp("R2", "unlocked erase row 9", 9);

        // R3 broken unlock patterns
        set_addr(12'h200); set_data(14'h0000);
        pb = n_prog_pulse; eb = n_erase_pulse;
        wr(RA_KEY, KEY_FIRST); wr(RA_ADDR_LO, 8'h00); wr(RA_KEY, KEY_SECOND); wr(RA_CTRL, 8'h03);
        no_start_check("write inside pattern", pb, eb);
        wr(RA_KEY, KEY_FIRST); wr(RA_KEY, KEY_SECOND); wr(RA_DATA_LO, 8'h00); wr(RA_CTRL, 8'h03);
        no_start_check("write after AAh", pb, eb);
        wr(RA_KEY, KEY_SECOND); wr(RA_KEY, KEY_FIRST); wr(RA_CTRL, 8'h03);
        no_start_check("keys reversed", pb, eb);
        wr(RA_CTRL, 8'h03);
        no_start_check("no key", pb, eb);
        wr(RA_KEY, KEY_FIRST); wr(RA_KEY, KEY_SECOND); wr(RA_CTRL, 8'h01); wr(RA_CTRL, 8'h03);
        no_start_check("enable low then retry", pb, eb);
        // R3 the latched word was never stored: a later program must not carry it
        set_addr(12'h201); set_data(14'h3FFF); do_op(1'b0, 1'b0, "R3");

        // R8 protection boundaries
        wp_cfg = 2'b10;
        set_addr(12'h3FF); set_data(14'h0001); do_op(1'b0, 1'b0, "R8");
        set_addr(12'h400); set_data(14'h0002); do_op(1'b0, 1'b0, "R8");
        wp_cfg = 2'b01;
        set_addr(12'h7E0); do_op(1'b1, 1'b0, "R8");
        set_addr(12'h800); do_op(1'b1, 1'b0, "R8");
        wp_cfg = 2'b00;
        set_addr(12'hFE0); do_op(1'b1, 1'b0, "R8");
        set_addr(12'hFE3); set_data(14'h1111); do_op(1'b0, 1'b1, "R8");
        set_addr(12'hFE4); do_op(1'b0, 1'b0, "R8");
        wp_cfg = 2'b11;
        set_addr(12'h000); do_op(1'b1, 1'b0, "R8");

        // random mix
        for (int it = 0; it < 30; it++) begin
            int row, op, k;
            wp_cfg = 2'($urandom % 4);
            row = $urandom % NROWS;
            op = $urandom % 3;
            if (op == 2) begin
                set_addr(row*RW + ($urandom % RW)); do_op(1'b1, 1'b0, "R6");
            end else begin
                k = 1 + ($urandom % 4);
                for (int j = 0; j < k; j++) begin
                    set_addr(row*RW + ($urandom % RW)); set_data($urandom % (1 << WORD_W));
                    do_op(1'b0, 1'b1, "R4");
                end
                set_addr(row*RW + ($urandom % RW)); set_data($urandom % (1 << WORD_W));
                do_op(1'b0, 1'b0, "R5");
            end
        end

        summary();
        $finish;
    end
endmodule